// File: doc/BRIEF.md
# Gated-Count Phase Error Detector

This block turns the timing gap between two one-bit signals into a digital number. It watches a reference input and a feedback input from a local oscillator, both asynchronous to a fast sampling clock. Both are resynchronised into that clock domain, and their rising edges are found there. A set/reset gate is set by each reference rising edge and cleared by the next feedback rising edge. While the gate is set, a counter advances once per fast-clock cycle.

The error word is therefore the number of fast-clock cycles from a reference edge to the feedback edge that follows it. At every reference rising edge the block captures the count reached so far as the error word, pulses a valid strobe for one cycle and restarts the count from zero. A phase-locked loop uses the word as its phase-error sample, once per reference period. The count saturates rather than wraps. A feedback edge that never arrives therefore reports full scale.

Top module: `phase_count_detector`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, err_word is 0 and err_valid is 0. A reset in the middle of operation discards any count in progress.
- R2: For inputs that are stable around each clk rising edge, a rising edge on ref_in that is first sampled at clk edge k makes err_valid high between clk edges k+2 and k+3, and err_valid is low between edges k+1 and k+2.
- R3: A reference rising edge sets the gate and a later feedback rising edge clears it. The reported count equals the number of clk cycles by which the feedback rising edge trails the reference rising edge.
- R4: At each reference rising edge, except the first one after reset, err_word takes the count accumulated since the previous reference edge and err_valid pulses. The counter then restarts at zero. err_word holds its value between these pulses.
- R5: The first reference rising edge after reset does not raise err_valid.
- R6: When a reference rising edge and a feedback rising edge are seen in the same cycle, the gate ends up cleared. That period's count is 0, and the count from the period that is ending is still reported.
- R7: The counter stops at all ones (255 for the default 8-bit width) rather than wrapping. If no feedback edge arrives, the next report is the number of elapsed cycles, capped at all ones.
- R8: A feedback rising edge while the gate is already clear has no effect on the count.
- R9: err_valid is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference signal, asynchronous |
| fb_in | input | 1 | Oscillator feedback signal, asynchronous |
| err_word | output | CNT_W | Phase error in fast-clock cycles |
| err_valid | output | 1 | One-cycle strobe when err_word is updated |

## Verification
Inputs change only on falling clock edges, so every edge is first sampled at a known rising edge. The result of a reference rise is due after the third rising edge that follows it. The bench therefore checks the strobe as low at the second falling edge of each period and checks the strobe and word at the third, then checks that the strobe is low again at the fourth. The count for a period is reported during the next period. Each scenario task therefore compares against the value it computed for the previous period from the feedback delay, the period length and the saturation limit.

// File: rtl/phase_count_detector.sv
module phase_count_detector #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  input  logic             fb_in,
  output logic [CNT_W-1:0] err_word,
  output logic             err_valid
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [SYNC_STAGES-1:0] ref_sync, fb_sync;
  logic                   ref_d, fb_d;
  logic                   ref_rise, fb_rise;
  logic                   gate, primed;
  logic [CNT_W-1:0]       cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_sync <= '0;
      fb_sync  <= '0;
      ref_d    <= 1'b0;
      fb_d     <= 1'b0;
    end else begin
      ref_sync <= {ref_sync[SYNC_STAGES-2:0], ref_in};
      fb_sync  <= {fb_sync[SYNC_STAGES-2:0], fb_in};
      ref_d    <= ref_sync[SYNC_STAGES-1];
      fb_d     <= fb_sync[SYNC_STAGES-1];
    end
  end

  assign ref_rise = ref_sync[SYNC_STAGES-1] & ~ref_d;
  assign fb_rise  = fb_sync[SYNC_STAGES-1]  & ~fb_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate <= 1'b0;
    end else if (ref_rise && fb_rise) begin
      gate <= 1'b0;
    end else if (ref_rise) begin
      gate <= 1'b1;
    end else if (fb_rise) begin
      gate <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (ref_rise) begin
      cnt <= '0;
    end else if (gate && cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_word  <= '0;
      err_valid <= 1'b0;
      primed    <= 1'b0;
    end else begin
      err_valid <= ref_rise & primed;
      if (ref_rise) begin
        primed <= 1'b1;
        if (primed) err_word <= cnt;
      end
    end
  end

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |=> !err_valid);

  // R4
  valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> $past(ref_rise));

  // R4
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_rise |=> $stable(err_word));

  // R4
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_rise |=> (cnt == '0));

  // R6
  coincident_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && fb_rise) |=> !gate);

  // R3
  fb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_rise && !ref_rise) |=> !gate);

  // R7
  saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !ref_rise) |=> (cnt == CNT_MAX));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate && !ref_rise) |=> $stable(cnt));

endmodule

// File: tb/tb_phase_count_detector.sv
module tb_phase_count_detector;

  localparam int CNT_W = 8;
  localparam int MAXV  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0;
  logic fb_in = 1'b0;
  logic [CNT_W-1:0] err_word;
  logic err_valid;

  int tests = 0;
  int fails = 0;
  int prev_exp = 0;
  bit prev_valid = 1'b0;

  always #4 clk = ~clk;

  phase_count_detector #(.CNT_W(CNT_W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
    .err_word(err_word), .err_valid(err_valid)
  );

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_n = 1'b0; ref_in = 1'b0; fb_in = 1'b0;
    repeat (3) @(negedge clk);
    check({tag, " word in reset"}, int'(err_word), 0);
    check({tag, " valid in reset"}, int'(err_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({tag, " word after reset"}, int'(err_word), 0);
    check({tag, " valid after reset"}, int'(err_valid), 0);
    prev_valid = 1'b0;
  endtask

  // One reference period of len cycles; feedback rises d cycles after the
  // reference when fb_on, plus an optional stray feedback pulse at extra.
  // Checks the report of the previous period.
  task automatic period(input int d, input bit fb_on, input int len,
                        input int extra, input string tag);
    ref_in = 1'b1;
    if (fb_on && d == 0) fb_in = 1'b1;
    for (int i = 1; i < len; i++) begin
      @(negedge clk);
      if (i == 2) ref_in = 1'b0;
      if (fb_on && i == d) fb_in = 1'b1;
      if (fb_on && i == d + 2) fb_in = 1'b0;
      if (extra > 0 && i == extra) fb_in = 1'b1;
      if (extra > 0 && i == extra + 2) fb_in = 1'b0;
      if (i == 2) check("R2 valid not early", int'(err_valid), 0);
      if (i == 3) begin
        check({tag, " valid"}, int'(err_valid), int'(prev_valid));
        if (prev_valid) check({tag, " word"}, int'(err_word), prev_exp);
      end
      if (i == 4) check("R9 valid one cycle", int'(err_valid), 0);
    end
    @(negedge clk);
    if (fb_on) prev_exp = (d > MAXV) ? MAXV : d;
    else prev_exp = (len - 1 > MAXV) ? MAXV : len - 1;
    prev_valid = 1'b1;
  endtask

  initial begin
    do_reset("R1");
    period(4, 1, 10, 0, "R5 first edge");
    period(7, 1, 12, 0, "R3 delay 4");
    period(1, 1, 8, 0, "R3 delay 7");
    period(0, 1, 8, 0, "R4 delay 1");
    period(5, 1, 15, 10, "R6 coincident zero");
    period(0, 0, 300, 0, "R8 stray fb ignored");
    period(0, 1, 8, 0, "R7 missing fb full scale");
    period(260, 1, 300, 0, "R6 coincident while gated");
    period(3, 1, 8, 0, "R7 saturated count");
    period(2, 1, 6, 0, "R4 delay 3");
    do_reset("R1 mid-run");
    period(3, 1, 8, 0, "R5 first edge after reset");
    period(6, 1, 10, 0, "R4 delay 3 after reset");
    period(2, 1, 6, 0, "R4 delay 6");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule